// File: doc/BRIEF.md
# Bit-Addressable GPIO Port Controller

This block holds four 8-bit bidirectional I/O ports for a small microcontroller core. Each port has an output latch and a direction register, both reachable through a byte-wide register port. Besides byte reads and writes, the register port accepts single-bit set, single-bit clear and whole-byte complement operations. Each of these reads the live port value, changes it and writes it back. Reads and bit operations see the synchronized pad level on pins set as inputs and the latch on pins set as outputs.

Two ports are narrower than eight bits. The missing bits read as zero, ignore writes and are never driven. One port can raise a wake-up request while the core sleeps. Pin 0 of a second port can carry a frequency output, gated by its own latch bit. Pin 0 of a third port feeds a timer input, and pin 0 of the fourth port feeds the external interrupt line. Pull-up enables are a build-time option for each pin. Pads appear as output-enable, output-value and pull-enable vectors, with bit 8*p+b standing for pin b of port p.

Top module: `gpio_portctl`

## Requirements
- R1: After reset every latch bit that exists is 1 and every direction bit that exists is 1. No pad is driven, and rdata_o and rvalid_o are 0.
- R2: The ports are numbered by data address: port 0 at 0x12, port 1 at 0x14, port 2 at 0x16 and port 3 at 0x1C. Each direction register sits at its data address plus one, and a direction bit of 1 means input. The op_i codes are 0 idle, 1 read, 2 write, 3 bit set, 4 bit clear and 5 complement. On the cycle after any non-idle op, rvalid_o is 1 and rdata_o holds the op's result. For a read the result is the register value, and for a write it is the stored value. An address that maps to no register returns 0 and changes nothing.
- R3: Reading a data register returns the pad level for input bits and the latch for output bits. The pad level passes through a two-stage synchronizer first.
- R4: Bit set and bit clear act on bit bitsel_i of the value R3 reads, or of the direction register. The whole result is written back, so the latch of every input-mode bit takes its current pad level.
- R5: Complement inverts the value that is read. With acc_dest_i at 0 the result is written back. With acc_dest_i at 1 only rdata_o carries the result and the register keeps its value.
- R6: Bits 7:6 of port 2 and bits 7:1 of port 3 do not exist. They read as 0, writes do not change them, and their output enable and pull enable stay 0.
- R7: An existing pin is driven (pad_oe_o at 1) exactly when its direction bit is 0. Its pad_out_o is its latch bit.
- R8: When ALT_EN is 1, pad_out_o[8] is the port 1 latch bit 0 ANDed with freq_i. When the pin is an input it is not driven, whatever the option.
- R9: wake_o is 1 for one cycle when sleep_i is 1 and a port 0 input-mode pin, after the synchronizer, goes from 1 to 0. A falling edge on an output-mode pin, or a falling edge while awake, gives no request.
- R10: tmr_in_o follows pad_in_i[16] and ext_irq_o follows pad_in_i[24], each delayed by the two synchronizer stages.
- R11: pad_pu_o of an existing pin is 1 when that pin's bit in PULLUP_MASK is 1 and the pin is an input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_i | input | 3 | Register operation code |
| addr_i | input | 8 | Register address |
| wdata_i | input | 8 | Byte write data |
| bitsel_i | input | 3 | Bit index for set and clear |
| acc_dest_i | input | 1 | Complement result to rdata_o only |
| rdata_o | output | 8 | Operation result |
| rvalid_o | output | 1 | rdata_o valid |
| pad_in_i | input | 32 | Pad input levels |
| pad_oe_o | output | 32 | Pad output enables |
| pad_out_o | output | 32 | Pad output values |
| pad_pu_o | output | 32 | Pad pull-up enables |
| freq_i | input | 1 | Frequency signal for the shared pin |
| sleep_i | input | 1 | Core is sleeping |
| wake_o | output | 1 | Wake-up request |
| tmr_in_o | output | 1 | Synchronized timer input |
| ext_irq_o | output | 1 | Synchronized interrupt input |

## Verification
The random phase mixes bit operations on ports whose pins are partly inputs, with pad levels that differ from the latch. A design that modified the latch alone, without first reading the pad, would leave stale latch bits, and these show up on the pads once the pins turn to outputs. Writes of all ones reach the narrow ports, so a design that stored or drove the missing bits would show them on rdata_o or pad_oe_o. Directed cases cover the following:
- complement to the result path, where a design that wrote the latch anyway would change the pads;
- the shared pin under both freq_i levels;
- wake-up from a falling edge while asleep, while awake, and on an output pin, where a wrong design would either miss the request or raise a false one;
- the exact cycle that the timer and interrupt taps change, which exposes a missing or extra synchronizer stage.

// File: rtl/gpio_pkg.sv
// Shared constants, the operation code and the modify step of the
// read-modify-write path of the GPIO port controller.
// Assumes four ports of eight pins each.
package gpio_pkg;
    localparam int NPORT = 4;
    localparam int PW    = 8;
    localparam int AW    = 8;
    localparam int BW    = $clog2(PW);

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_READ  = 3'd1,
        OP_WRITE = 3'd2,
        OP_SET   = 3'd3,
        OP_CLR   = 3'd4,
        OP_CPL   = 3'd5
    } gpio_op_e;

    localparam logic [AW-1:0] PORT_ADDR [NPORT] = '{8'h12, 8'h14, 8'h16, 8'h1C};
    localparam logic [PW-1:0] PORT_IMPL [NPORT] = '{8'hFF, 8'hFF, 8'h3F, 8'h01};

    // Apply one operation to the value that was read.
    function automatic logic [PW-1:0] apply_op(
        input gpio_op_e        op,
        input logic [BW-1:0]   sel,
        input logic [PW-1:0]   cur,
        input logic [PW-1:0]   wdat
    );
        logic [PW-1:0] onehot;
        onehot = PW'(1) << sel;
        case (op)
            OP_WRITE: apply_op = wdat;
            OP_SET:   apply_op = cur | onehot;
            OP_CLR:   apply_op = cur & ~onehot;
            OP_CPL:   apply_op = ~cur;
            default:  apply_op = cur;
        endcase
    endfunction
endpackage

// File: rtl/gpio_sync.sv
// Two-stage synchronizer for asynchronous pad inputs.
// Assumes the inputs idle high (pull-ups), so the stages reset to ones.
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    // Shift the pad levels through the two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1_q <= '1;
            stage2_q <= '1;
        end else begin
            stage1_q <= async_i;
            stage2_q <= stage1_q;
        end
    end

    assign sync_o = stage2_q;
endmodule

// File: rtl/gpio_port.sv
// One I/O port: output latch and direction register, with the
// read-modify-write operation path. Missing bits (IMPL = 0) are held at 0.
// Assumes pin_i is already synchronized.
module gpio_port
    import gpio_pkg::*;
#(
    parameter logic [AW-1:0] DATA_ADDR = 8'h12,
    parameter logic [PW-1:0] IMPL      = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  gpio_op_e      op_i,
    input  logic [AW-1:0] addr_i,
    input  logic [PW-1:0] wdata_i,
    input  logic [BW-1:0] bitsel_i,
    input  logic          acc_dest_i,
    input  logic [PW-1:0] pin_i,
    output logic [PW-1:0] result_o,
    output logic [PW-1:0] latch_o,
    output logic [PW-1:0] dir_o
);
    localparam logic [AW-1:0] DIR_ADDR = DATA_ADDR + AW'(1);

    logic          data_hit;
    logic          dir_hit;
    logic [PW-1:0] latch_q;
    logic [PW-1:0] dir_q;
    logic [PW-1:0] live_val;
    logic [PW-1:0] cur_val;
    logic [PW-1:0] new_val;
    logic          do_write;

    assign data_hit = (addr_i == DATA_ADDR);
    assign dir_hit  = (addr_i == DIR_ADDR);

    // Port state: pad level on inputs, latch on outputs.
    always_comb begin
        live_val = ((dir_q & pin_i) | (~dir_q & latch_q)) & IMPL;
        cur_val  = data_hit ? live_val : (dir_q & IMPL);
        new_val  = apply_op(op_i, bitsel_i, cur_val, wdata_i) & IMPL;
    end

    // Decide whether the operation stores its result.
    always_comb begin
        case (op_i)
            OP_WRITE, OP_SET, OP_CLR: do_write = 1'b1;
            OP_CPL:                   do_write = !acc_dest_i;
            default:                  do_write = 1'b0;
        endcase
    end

    // Latch register, reset to ones on existing bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            latch_q <= IMPL;
        end else if (data_hit && do_write) begin
            latch_q <= new_val;
        end
    end

    // Direction register, reset to all inputs on existing bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q <= IMPL;
        end else if (dir_hit && do_write) begin
            dir_q <= new_val;
        end
    end

    assign result_o = (data_hit || dir_hit) ? new_val : '0;
    assign latch_o  = latch_q;
    assign dir_o    = dir_q;
endmodule

// File: rtl/gpio_pad_mux.sv
// Pad drive for all pins: output enable, output value and pull enable.
// Pin 0 of port ALT_PORT can carry freq_i, gated by its latch bit.
// Assumes missing bits have latch and direction held at 0.
module gpio_pad_mux
    import gpio_pkg::*;
#(
    parameter int               ALT_PORT    = 1,
    parameter bit               ALT_EN      = 1'b1,
    parameter logic [NPORT*PW-1:0] PULLUP_MASK = '1
) (
    input  logic [NPORT*PW-1:0] latch_i,
    input  logic [NPORT*PW-1:0] dir_i,
    input  logic                freq_i,
    output logic [NPORT*PW-1:0] oe_o,
    output logic [NPORT*PW-1:0] out_o,
    output logic [NPORT*PW-1:0] pu_o
);
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        for (genvar b = 0; b < PW; b++) begin : g_bit
            localparam int  IDX = p*PW + b;
            localparam bit  HAS = PORT_IMPL[p][b];
            if (!HAS) begin : g_absent
                assign oe_o[IDX]  = 1'b0;
                assign out_o[IDX] = 1'b0;
                assign pu_o[IDX]  = 1'b0;
            end else begin : g_present
                assign oe_o[IDX] = !dir_i[IDX];
                assign pu_o[IDX] = PULLUP_MASK[IDX] && dir_i[IDX];
                if (ALT_EN && p == ALT_PORT && b == 0) begin : g_alt
                    assign out_o[IDX] = latch_i[IDX] & freq_i;
                end else begin : g_plain
                    assign out_o[IDX] = latch_i[IDX];
                end
            end
        end
    end
endmodule

// File: rtl/gpio_wake.sv
// Wake-up detector: a falling edge on any input-mode pin of the
// watched port while sleeping raises a one-cycle request.
// Assumes pin_i is already synchronized.
module gpio_wake #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    input  logic [W-1:0] dir_i,
    input  logic         sleep_i,
    output logic         wake_o
);
    logic [W-1:0] prev_q;

    // Remember last cycle's synchronized levels.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= pin_i;
    end

    assign wake_o = sleep_i && |(prev_q & ~pin_i & dir_i);
endmodule

// File: rtl/gpio_portctl.sv
// Top of the GPIO port controller: four ports, register access with
// bit operations, pad drive, wake-up and synchronized pin taps.
// Assumes a single clock and synchronous active-low reset.
module gpio_portctl
    import gpio_pkg::*;
#(
    parameter bit                  ALT_EN      = 1'b1,
    parameter logic [NPORT*PW-1:0] PULLUP_MASK = 32'hFFFF_00FF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [2:0]          op_i,
    input  logic [AW-1:0]       addr_i,
    input  logic [PW-1:0]       wdata_i,
    input  logic [BW-1:0]       bitsel_i,
    input  logic                acc_dest_i,
    output logic [PW-1:0]       rdata_o,
    output logic                rvalid_o,
    input  logic [NPORT*PW-1:0] pad_in_i,
    output logic [NPORT*PW-1:0] pad_oe_o,
    output logic [NPORT*PW-1:0] pad_out_o,
    output logic [NPORT*PW-1:0] pad_pu_o,
    input  logic                freq_i,
    input  logic                sleep_i,
    output logic                wake_o,
    output logic                tmr_in_o,
    output logic                ext_irq_o
);
    localparam int ALT_PORT  = 1;
    localparam int WAKE_PORT = 0;
    localparam int TMR_PORT  = 2;
    localparam int IRQ_PORT  = 3;

    gpio_op_e            op;
    logic [NPORT*PW-1:0] pin_sync;
    logic [NPORT*PW-1:0] latch_all;
    logic [NPORT*PW-1:0] dir_all;
    logic [PW-1:0]       result [NPORT];
    logic [PW-1:0]       result_or;
    logic [PW-1:0]       rdata_q;
    logic                rvalid_q;

    assign op = gpio_op_e'(op_i);

    gpio_sync #(.W(NPORT*PW)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pad_in_i),
        .sync_o (pin_sync)
    );

    for (genvar p = 0; p < NPORT; p++) begin : g_ports
        gpio_port #(
            .DATA_ADDR(PORT_ADDR[p]),
            .IMPL     (PORT_IMPL[p])
        ) u_port (
            .clk       (clk),
            .rst_n     (rst_n),
            .op_i      (op),
            .addr_i    (addr_i),
            .wdata_i   (wdata_i),
            .bitsel_i  (bitsel_i),
            .acc_dest_i(acc_dest_i),
            .pin_i     (pin_sync[p*PW +: PW]),
            .result_o  (result[p]),
            .latch_o   (latch_all[p*PW +: PW]),
            .dir_o     (dir_all[p*PW +: PW])
        );
    end

    // Merge the per-port results; at most one port decodes an address.
    always_comb begin
        result_or = '0;
        for (int p = 0; p < NPORT; p++) result_or |= result[p];
    end

    // Register the operation result for the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q  <= '0;
            rvalid_q <= 1'b0;
        end else begin
            rvalid_q <= (op != OP_NONE);
            if (op != OP_NONE) rdata_q <= result_or;
        end
    end

    assign rdata_o  = rdata_q;
    assign rvalid_o = rvalid_q;

    gpio_pad_mux #(
        .ALT_PORT   (ALT_PORT),
        .ALT_EN     (ALT_EN),
        .PULLUP_MASK(PULLUP_MASK)
    ) u_pads (
        .latch_i(latch_all),
        .dir_i  (dir_all),
        .freq_i (freq_i),
        .oe_o   (pad_oe_o),
        .out_o  (pad_out_o),
        .pu_o   (pad_pu_o)
    );

    gpio_wake #(.W(PW)) u_wake (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_sync[WAKE_PORT*PW +: PW]),
        .dir_i  (dir_all[WAKE_PORT*PW +: PW]),
        .sleep_i(sleep_i),
        .wake_o (wake_o)
    );

    assign tmr_in_o  = pin_sync[TMR_PORT*PW];
    assign ext_irq_o = pin_sync[IRQ_PORT*PW];
endmodule

// File: rtl/gpio_portctl_chk.sv
// Property checker for gpio_portctl, attached through bind.
// Observes ports only.
module gpio_portctl_chk
    import gpio_pkg::*;
#(
    parameter bit ALT_EN = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2:0]          op_i,
    input logic [AW-1:0]       addr_i,
    input logic [PW-1:0]       wdata_i,
    input logic [PW-1:0]       rdata_o,
    input logic                rvalid_o,
    input logic [NPORT*PW-1:0] pad_oe_o,
    input logic [NPORT*PW-1:0] pad_out_o,
    input logic [NPORT*PW-1:0] pad_pu_o,
    input logic                freq_i,
    input logic                sleep_i,
    input logic                wake_o
);
    assert_reset_undriven_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (pad_oe_o == '0));

    assert_op_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd0) |=> rvalid_o);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd2 && addr_i == 8'h12) |=> (pad_out_o[7:0] == $past(wdata_i)));

    assert_absent_undriven_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe_o[23:22] == 2'b00) && (pad_oe_o[31:25] == 7'd0)
        && (pad_pu_o[23:22] == 2'b00) && (pad_pu_o[31:25] == 7'd0));

    assert_absent_reads_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i != 3'd0 && (addr_i == 8'h1C || addr_i == 8'h1D)) |=> (rdata_o[7:1] == 7'd0));

    assert_alt_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ALT_EN && pad_out_o[8]) |-> freq_i);

    assert_wake_asleep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> sleep_i);
endmodule

bind gpio_portctl gpio_portctl_chk #(.ALT_EN(ALT_EN)) u_chk (.*);

// File: tb/gpio_portctl_tb.sv
// Self-checking bench: directed corners plus seeded random operations
// compared against a bench-side model of the port registers.
module gpio_portctl_tb;
    localparam logic [31:0] PU   = 32'hFFFF_00FF;
    localparam logic [31:0] IMPL = 32'h013F_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_i = '0;
    logic [7:0]  addr_i = '0;
    logic [7:0]  wdata_i = '0;
    logic [2:0]  bitsel_i = '0;
    logic        acc_dest_i = 1'b0;
    logic [7:0]  rdata_o;
    logic        rvalid_o;
    logic [31:0] pad_in_i = '1;
    logic [31:0] pad_oe_o, pad_out_o, pad_pu_o;
    logic        freq_i = 1'b0;
    logic        sleep_i = 1'b0;
    logic        wake_o, tmr_in_o, ext_irq_o;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] m_latch = IMPL;
    logic [31:0] m_dir   = IMPL;

    always #5 clk = ~clk;

    gpio_portctl #(.ALT_EN(1'b1), .PULLUP_MASK(PU)) u_dut (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic int port_of(input logic [7:0] a);
        case (a)
            8'h12, 8'h13: return 0;
            8'h14, 8'h15: return 1;
            8'h16, 8'h17: return 2;
            8'h1C, 8'h1D: return 3;
            default:      return -1;
        endcase
    endfunction

    function automatic logic [31:0] exp_out();
        logic [31:0] o;
        o = m_latch & IMPL;
        o[8] = m_latch[8] & freq_i;
        return o;
    endfunction

    task automatic check_pads(input string tag);
        check({tag, " R7 oe"}, pad_oe_o, ~m_dir & IMPL);
        check({tag, " R7/R8 out"}, pad_out_o, exp_out());
        check({tag, " R11 pu"}, pad_pu_o, PU & m_dir & IMPL);
    endtask

    // Apply one op, update the model, check result and pads.
    task automatic do_op(input logic [2:0] op, input logic [7:0] a, input logic [7:0] wd,
                         input logic [2:0] bs, input logic acc);
        int p;
        logic [7:0] msk, cur, res, one;
        logic       is_dir;
        p = port_of(a);
        is_dir = a[0] ^ (a == 8'h1C || a == 8'h1D ? 1'b0 : 1'b0);
        is_dir = (p >= 0) && (a == 8'h13 || a == 8'h15 || a == 8'h17 || a == 8'h1D);
        res = 8'h00;
        if (p >= 0) begin
            msk = IMPL[p*8 +: 8];
            if (is_dir) cur = m_dir[p*8 +: 8] & msk;
            else cur = ((m_dir[p*8 +: 8] & pad_in_i[p*8 +: 8]) |
                        (~m_dir[p*8 +: 8] & m_latch[p*8 +: 8])) & msk;
            one = 8'h01 << bs;
            case (op)
                3'd2: res = wd;
                3'd3: res = cur | one;
                3'd4: res = cur & ~one;
                3'd5: res = ~cur;
                default: res = cur;
            endcase
            res &= msk;
            if (op inside {3'd2, 3'd3, 3'd4} || (op == 3'd5 && !acc)) begin
                if (is_dir) m_dir[p*8 +: 8] = res;
                else m_latch[p*8 +: 8] = res;
            end
        end
        @(negedge clk);
        op_i = op; addr_i = a; wdata_i = wd; bitsel_i = bs; acc_dest_i = acc;
        @(negedge clk);
        op_i = '0;
        check(op == 3'd1 ? "R2/R3 read" : op == 3'd2 ? "R2 write" :
              op == 3'd5 ? "R5 cpl" : "R4 bitop", {24'h0, rdata_o}, {24'h0, res});
        check("R2 rvalid", {31'h0, rvalid_o}, 32'd1);
        check_pads("op");
    endtask

    task automatic settle_pads(input logic [31:0] v);
        @(negedge clk);
        pad_in_i = v;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int seed;
        seed = 32'h5eed_0042;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", {24'h0, rdata_o}, 32'h0);
        check("R1 rvalid", {31'h0, rvalid_o}, 32'h0);
        check("R1 oe", pad_oe_o, 32'h0);
        check("R1 pu", pad_pu_o, PU & IMPL);
        check("R1 out", pad_out_o, exp_out());

        // R6: narrow ports, all-ones written then read back
        do_op(3'd2, 8'h17, 8'h00, 3'd0, 1'b0);
        do_op(3'd2, 8'h16, 8'hFF, 3'd0, 1'b0);
        do_op(3'd1, 8'h16, 8'h00, 3'd0, 1'b0);
        do_op(3'd2, 8'h1D, 8'h00, 3'd0, 1'b0);
        do_op(3'd3, 8'h1C, 8'h00, 3'd7, 1'b0);
        do_op(3'd1, 8'h1D, 8'h00, 3'd0, 1'b0);
        // R2 unmapped
        do_op(3'd2, 8'h20, 8'hA5, 3'd0, 1'b0);
        do_op(3'd1, 8'h20, 8'h00, 3'd0, 1'b0);
        // R4 RMW captures pad level of input bits
        settle_pads(32'h0000_0F00);
        do_op(3'd2, 8'h14, 8'hFF, 3'd0, 1'b0);
        do_op(3'd2, 8'h15, 8'hF0, 3'd0, 1'b0);
        do_op(3'd4, 8'h14, 8'h00, 3'd0, 1'b0);
        do_op(3'd2, 8'h15, 8'h00, 3'd0, 1'b0);
        // R5 complement to result only, then to latch
        do_op(3'd5, 8'h14, 8'h00, 3'd0, 1'b1);
        do_op(3'd5, 8'h14, 8'h00, 3'd0, 1'b0);
        // R8 shared pin under both freq levels
        do_op(3'd2, 8'h14, 8'h01, 3'd0, 1'b0);
        freq_i = 1'b1; #1 check_pads("R8 f1");
        freq_i = 1'b0; #1 check_pads("R8 f0");
        do_op(3'd2, 8'h15, 8'h01, 3'd0, 1'b0);
        freq_i = 1'b1; #1 check("R8 input undriven", {31'h0, pad_oe_o[8]}, 32'h0);

        // R10 taps: two-stage delay
        settle_pads(32'hFFFF_FFFF);
        @(negedge clk); pad_in_i[16] = 1'b0; pad_in_i[24] = 1'b0;
        @(negedge clk);
        check("R10 tmr stage1", {31'h0, tmr_in_o}, 32'h1);
        check("R10 irq stage1", {31'h0, ext_irq_o}, 32'h1);
        @(negedge clk);
        check("R10 tmr", {31'h0, tmr_in_o}, 32'h0);
        check("R10 irq", {31'h0, ext_irq_o}, 32'h0);

        // R9 wake-up
        do_op(3'd2, 8'h13, 8'hFE, 3'd0, 1'b0);
        settle_pads(32'hFFFF_FFFF);
        sleep_i = 1'b1;
        @(negedge clk); pad_in_i[3] = 1'b0;
        @(negedge clk); check("R9 not yet", {31'h0, wake_o}, 32'h0);
        @(negedge clk); check("R9 wake", {31'h0, wake_o}, 32'h1);
        @(negedge clk); check("R9 one cycle", {31'h0, wake_o}, 32'h0);
        settle_pads(32'hFFFF_FFFF);
        @(negedge clk); pad_in_i[0] = 1'b0;
        repeat (2) @(negedge clk); check("R9 output pin", {31'h0, wake_o}, 32'h0);
        settle_pads(32'hFFFF_FFFF);
        sleep_i = 1'b0;
        @(negedge clk); pad_in_i[5] = 1'b0;
        repeat (2) @(negedge clk); check("R9 awake", {31'h0, wake_o}, 32'h0);

        // Random mix (R2 R3 R4 R5 R6 R7 R11)
        for (int i = 0; i < 600; i++) begin
            logic [7:0] a;
            if (i % 25 == 0) begin
                settle_pads($urandom);
                freq_i = 1'($urandom);
            end
            case ($urandom_range(0, 8))
                0: a = 8'h12; 1: a = 8'h13; 2: a = 8'h14; 3: a = 8'h15;
                4: a = 8'h16; 5: a = 8'h17; 6: a = 8'h1C; 7: a = 8'h1D;
                default: a = 8'h1E;
            endcase
            do_op(3'($urandom_range(1, 5)), a, 8'($urandom), 3'($urandom), 1'($urandom));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule